// File: doc/BRIEF.md
# Chip-8 control-flow execution unit

This unit carries out the four Chip-8 control-transfer instructions: plain jump (`1NNN`), subroutine call (`2NNN`), subroutine return (`00EE`) and jump offset by register V0 (`BNNN`). A sequencer presents an instruction word and the current V0 value with a one-clock `start` pulse. The unit owns the 16-bit program counter and the return-stack pointer. Return addresses live as single bytes in ordinary data memory, reached through a byte-wide port whose read data arrives one clock after the address.

Completion is tied to a machine-cycle budget for each instruction. A `mcyc_en` strobe marks machine cycles, and the unit counts only those strobes. When the budget for the instruction is used up, `done` pulses, and in that same edge the program counter and stack pointer take their new values. Budgets are 12 for jump, 26 for call, 10 for return, and 22 or 24 for the offset jump, depending on whether its target leaves the page of `NNN`.

Top module: `c8_flow_unit`

## Requirements
- R1: After reset, `pc` equals START_PC (0x0200), `sp` equals STACK_TOP (0x0EA0), and `done`, `illegal` and `mem_we` are low.
- R2: Instruction `1NNN` (bits 15:12 = 1) loads `pc` with 0x0NNN. It leaves `sp` unchanged and writes no memory.
- R3: Instruction `2NNN` (bits 15:12 = 2) computes return address R = `pc`+2. It writes R[7:0] to address `sp`-1 and then R[15:8] to address `sp`-2. It then sets `sp` to `sp`-2 and `pc` to 0x0NNN.
- R4: Instruction `00EE` (the whole word 0x00EE) reads the high byte at `sp` and the low byte at `sp`+1, with read data arriving one clock after its address. It loads `pc` with {high, low} and sets `sp` to `sp`+2.
- R5: Instruction `BNNN` (bits 15:12 = 0xB) sets `pc` to the full 16-bit sum 0x0NNN + V0. A carry out of the low byte raises the high byte, so 0xBFFF with V0 = 0xFF gives 0x10FE. `sp` is unchanged.
- R6: `BNNN` takes 22 machine cycles when NNN[7:0]+V0 < 256 and 24 when the sum carries.
- R7: `done` rises in the clock that follows the edge at which the budget-th sampled-high `mcyc_en` after the start edge is seen. The budgets are 1NNN:12, 2NNN:26, 00EE:10. Clocks with `mcyc_en` low do not count.
- R8: Any other instruction word raises `illegal` for exactly one clock, in the clock after the start edge. It gives no `done`, no memory write and no change to `pc` or `sp`.
- R9: A `start` seen while an instruction is executing is ignored. It produces no `illegal` pulse and does not alter the running instruction's result or budget.
- R10: `done` lasts one clock, and `pc` and `sp` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` (accepted only when idle) |
| instr | input | 16 | Instruction word |
| v0 | input | 8 | Value of register V0, sampled with `start` |
| mcyc_en | input | 1 | Machine-cycle strobe that advances the budget counter |
| done | output | 1 | One-clock completion pulse |
| illegal | output | 1 | One-clock pulse for an unsupported word |
| pc | output | 16 | Program counter |
| sp | output | 16 | Return-stack pointer |
| mem_addr | output | 16 | Stack memory byte address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| mem_rdata | input | 8 | Stack memory read data, one clock after address |

## Verification
The `illegal` pulse is due in the first clock after the start edge, and the bench samples it on the following falling edge and once more to see it drop. `done` is due one clock after the edge that samples the last budgeted strobe. After each start, the bench counts sampled-high strobes at rising edges and stops at the first falling edge where `done` is high, so the count must equal the budget exactly. It then reads `pc`, `sp` and its own memory model, and checks one falling edge later that `done` has dropped. Strobe patterns with gaps stretch the wall-clock time while keeping that count fixed.

// File: rtl/c8_flow_unit.sv
module c8_flow_unit #(
  parameter logic [15:0] START_PC     = 16'h0200,
  parameter logic [15:0] STACK_TOP    = 16'h0EA0,
  parameter int          CYC_JUMP     = 12,
  parameter int          CYC_CALL     = 26,
  parameter int          CYC_RET      = 10,
  parameter int          CYC_OFS      = 22,
  parameter int          CYC_OFS_PAGE = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] instr,
  input  logic [7:0]  v0,
  input  logic        mcyc_en,
  output logic        done,
  output logic        illegal,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata
);
  localparam int M1   = (CYC_JUMP > CYC_RET) ? CYC_JUMP : CYC_RET;
  localparam int M2   = (CYC_CALL > CYC_OFS_PAGE) ? CYC_CALL : CYC_OFS_PAGE;
  localparam int CMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {K_JUMP, K_CALL, K_RET, K_OFS} kind_t;

  kind_t         kind;
  logic          busy;
  logic [1:0]    ph;
  logic [CW-1:0] cnt, budget;
  logic [15:0]   tgt;

  wire is_jump = instr[15:12] == 4'h1;
  wire is_call = instr[15:12] == 4'h2;
  wire is_ofs  = instr[15:12] == 4'hB;
  wire is_ret  = instr == 16'h00EE;
  wire legal   = is_jump | is_call | is_ofs | is_ret;
  wire accept  = start & ~busy;

  wire [8:0]  lo_sum  = {1'b0, instr[7:0]} + {1'b0, v0};
  wire [15:0] ofs_tgt = {8'h00, 4'h0, instr[11:8]} + {15'd0, lo_sum[8]};
  wire [15:0] ret_adr = pc + 16'd2;

  assign mem_we    = busy && kind == K_CALL && !ph[1];
  assign mem_wdata = ph[0] ? ret_adr[15:8] : ret_adr[7:0];
  always_comb begin
    mem_addr = sp;
    if (busy && kind == K_CALL) mem_addr = ph[0] ? sp - 16'd2 : sp - 16'd1;
    else if (busy && kind == K_RET && ph != 2'd0) mem_addr = sp + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      kind    <= K_JUMP;
      ph      <= 2'd0;
      cnt     <= '0;
      budget  <= '0;
      tgt     <= 16'h0000;
      pc      <= START_PC;
      sp      <= STACK_TOP;
    end else begin
      done    <= 1'b0;
      illegal <= accept & ~legal;
      if (accept && legal) begin
        busy <= 1'b1;
        ph   <= 2'd0;
        cnt  <= '0;
        if (is_jump) begin
          kind <= K_JUMP; budget <= CW'(CYC_JUMP); tgt <= {4'h0, instr[11:0]};
        end else if (is_call) begin
          kind <= K_CALL; budget <= CW'(CYC_CALL); tgt <= {4'h0, instr[11:0]};
        end else if (is_ofs) begin
          kind   <= K_OFS;
          budget <= lo_sum[8] ? CW'(CYC_OFS_PAGE) : CW'(CYC_OFS);
          tgt    <= {ofs_tgt[7:0], lo_sum[7:0]};
        end else begin
          kind <= K_RET; budget <= CW'(CYC_RET);
        end
      end else if (busy) begin
        if (ph != 2'd3) ph <= ph + 2'd1;
        if (kind == K_RET && ph == 2'd1) tgt[15:8] <= mem_rdata;
        if (kind == K_RET && ph == 2'd2) tgt[7:0]  <= mem_rdata;
        if (mcyc_en) begin
          if (cnt == budget - CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            pc   <= tgt;
            if (kind == K_CALL) sp <= sp - 16'd2;
            else if (kind == K_RET) sp <= sp + 16'd2;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

module c8_flow_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        illegal,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic [15:0] mem_addr,
  input logic        mem_we
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r10_pc_only_at_done: assert property (@(posedge clk) disable iff (!rst_n) !$stable(pc) |-> done);
  a_r10_sp_only_at_done: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sp) |-> done);
  a_r8_illegal_single: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> !illegal);
  a_r8_no_done_with_illegal: assert property (@(posedge clk) disable iff (!rst_n) !(done && illegal));
  a_r3_write_below_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == sp - 16'd1 || mem_addr == sp - 16'd2));
endmodule

bind c8_flow_unit c8_flow_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .illegal(illegal),
  .pc(pc), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/sim_c8_flow_unit.sv
module sim_c8_flow_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [7:0]  v0 = 8'h00;
  logic        mcyc_en = 1'b0;
  logic        done, illegal, mem_we;
  logic [15:0] pc, sp, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  rd_q = 8'h00;
  logic [7:0]  mem [0:4095];

  int nchk = 0, nerr = 0, wr_cnt = 0;
  bit ill_seen = 0;
  logic [15:0] exp_pc, exp_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  c8_flow_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .v0(v0),
    .mcyc_en(mcyc_en), .done(done), .illegal(illegal), .pc(pc), .sp(sp),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(rd_q)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    rd_q <= mem[mem_addr[11:0]];
    if (illegal) ill_seen <= 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exec(input logic [15:0] ins, input logic [7:0] v, input bit slow,
                      input bit poke, output int nen);
    @(negedge clk);
    instr = ins; v0 = v; start = 1'b1; mcyc_en = 1'b0;
    wr_cnt = 0; ill_seen = 0;
    @(negedge clk);
    start = 1'b0;
    nen = 0;
    for (int k = 0; k < 400; k++) begin
      mcyc_en = slow ? (k % 3 == 0) : 1'b1;
      start = poke && (k == 3);
      if (poke && k == 3) instr = (k[0]) ? 16'h5000 : 16'hB123;
      @(posedge clk);
      if (mcyc_en) nen++;
      @(negedge clk);
      if (done) break;
    end
    mcyc_en = 1'b0;
    start = 1'b0;
  endtask

  function automatic int ofs_budget(input logic [11:0] n, input logic [7:0] v);
    return ({1'b0, n[7:0]} + {1'b0, v}) > 9'd255 ? 24 : 22;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int nen;
    logic [15:0] ret_stack [0:7];
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 16'h0200);
    chk("R1 sp", sp, 16'h0EA0);
    chk("R1 flags", {done, illegal, mem_we}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc, 16'h0200);
    exp_pc = 16'h0200; exp_sp = 16'h0EA0;

    // R2 / R7: jump sweep, alternating dense and gapped strobes
    for (int k = 0; k < 16; k++) begin
      logic [11:0] n;
      n = 12'((k * 273 + 5) ^ (k << 7));
      exec({4'h1, n}, 8'h00, k[0], 1'b0, nen);
      exp_pc = {4'h0, n};
      chk("R2 jump pc", pc, exp_pc);
      chk("R2 jump sp", sp, exp_sp);
      chk("R2 no writes", wr_cnt, 0);
      chk(k[0] ? "R7 gapped budget" : "R7 jump budget", nen, 12);
      @(negedge clk);
      chk("R10 done single", done, 1'b0);
    end

    // R3: nested calls
    exec(16'h1300, 8'h00, 1'b0, 1'b0, nen);
    exp_pc = 16'h0300;
    for (int d = 0; d < 8; d++) begin
      logic [11:0] t;
      t = 12'(16'h0400 + d * 16'h0132);
      ret_stack[d] = exp_pc + 16'd2;
      exec({4'h2, t}, 8'h00, d[0], 1'b0, nen);
      exp_sp = exp_sp - 16'd2;
      exp_pc = {4'h0, t};
      chk("R3 call pc", pc, exp_pc);
      chk("R3 call sp", sp, exp_sp);
      chk("R3 low byte", mem[12'(exp_sp + 16'd1)], ret_stack[d][7:0]);
      chk("R3 high byte", mem[12'(exp_sp)], ret_stack[d][15:8]);
      chk("R3 writes", wr_cnt, 2);
      chk("R7 call budget", nen, 26);
    end

    // R4: unwind
    for (int d = 7; d >= 0; d--) begin
      exec(16'h00EE, 8'h00, d[0], 1'b0, nen);
      exp_sp = exp_sp + 16'd2;
      exp_pc = ret_stack[d];
      chk("R4 ret pc", pc, exp_pc);
      chk("R4 ret sp", sp, exp_sp);
      chk("R4 no writes", wr_cnt, 0);
      chk("R7 ret budget", nen, 10);
    end

    // R5 / R6: offset jump sweep
    for (int a = 0; a < 7; a++) begin
      logic [11:0] n;
      case (a)
        0: n = 12'h000; 1: n = 12'h0F0; 2: n = 12'h1FF; 3: n = 12'hFFF;
        4: n = 12'h880; 5: n = 12'h234; default: n = 12'hA01;
      endcase
      for (int b = 0; b < 6; b++) begin
        logic [7:0] v;
        case (b)
          0: v = 8'h00; 1: v = 8'h01; 2: v = 8'h0F; 3: v = 8'h80; 4: v = 8'hFE; default: v = 8'hFF;
        endcase
        exec({4'hB, n}, v, 1'b0, 1'b0, nen);
        exp_pc = {4'h0, n} + {8'h00, v};
        chk("R5 offset pc", pc, exp_pc);
        chk("R5 offset sp", sp, exp_sp);
        chk("R6 offset budget", nen, ofs_budget(n, v));
      end
    end
    exec(16'hBFFF, 8'hFF, 1'b1, 1'b0, nen);
    chk("R5 beyond 12 bits", pc, 16'h10FE);
    chk("R6 page cross", nen, 24);

    // R8: unsupported words
    for (int top = 0; top < 19; top++) begin
      logic [15:0] w;
      if (top == 1 || top == 2 || top == 11) continue;
      w = (top < 16) ? {4'(top), 12'h3C5} : (top == 16 ? 16'h00E0 : (top == 17 ? 16'h00EF : 16'h01EE));
      exp_pc = pc;
      @(negedge clk);
      instr = w; start = 1'b1; mcyc_en = 1'b1; wr_cnt = 0;
      @(negedge clk);
      start = 1'b0;
      chk("R8 illegal pulse", illegal, 1'b1);
      @(negedge clk);
      chk("R8 illegal drops", illegal, 1'b0);
      repeat (30) begin
        @(negedge clk);
        if (done) break;
      end
      chk("R8 no done", done, 1'b0);
      chk("R8 pc kept", pc, exp_pc);
      chk("R8 sp kept", sp, exp_sp);
      chk("R8 no writes", wr_cnt, 0);
      mcyc_en = 1'b0;
    end

    // R9: start while busy
    exec(16'h1456, 8'h00, 1'b0, 1'b1, nen);
    chk("R9 pc unaffected", pc, 16'h0456);
    chk("R9 budget unaffected", nen, 12);
    chk("R9 no illegal", ill_seen, 1'b0);
    exec(16'h2777, 8'h00, 1'b1, 1'b1, nen);
    chk("R9 call pc", pc, 16'h0777);
    chk("R9 call sp", sp, exp_sp - 16'd2);
    chk("R9 call budget", nen, 26);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule